// File: doc/BRIEF.md
# Sample FIFO with Data-Available Trigger

This block sits between an acquisition front end and a host bus interface. Converted 12-bit samples are pushed into a 16-entry first-in first-out buffer. The host pops them one at a time. A data-available line tells the host when a programmable number of samples is waiting. The fill threshold comes from a 2-bit select, and what each select value means depends on how many channels are active. A single-ended channel and a differential channel each count as one channel.

The data-available line can be a steady level or a single-clock pulse, with either polarity. Pulse mode is controlled by a three-state machine:

- `AV_ARMED`: the fill is below the threshold.
- `AV_FIRE`: the one cycle in which the pulse is driven.
- `AV_HELD`: the fill is at or above the threshold and the pulse has already been issued.

The state machine moves between these states as follows:

- *reach*: `AV_ARMED` goes to `AV_FIRE` when the fill is at or above the threshold.
- *settle*: `AV_FIRE` goes to `AV_HELD` while the fill stays at or above the threshold.
- *drop*: `AV_FIRE` goes to `AV_ARMED` if the fill has fallen below the threshold.
- *rearm*: `AV_HELD` goes to `AV_ARMED` once the fill falls below the threshold.
- *restart*: any state goes to `AV_ARMED` on a buffer clear or a device reset.

The block also keeps a sticky overflow flag, which the host clears by reading its status. A buffer clear request empties the buffer. A device reset request empties the buffer and also returns the block's own state to its reset values. Everything is clocked by one clock.

Top module: `sfifo_trig`

## Requirements
- R1: Samples are read out in the order they were written. `rd_data` shows the popped sample right after the clock edge at which `rd_en` was sampled high with the buffer non-empty.
- R2: The buffer holds up to 16 samples. A write while it is full is dropped, and the samples already stored are unchanged.
- R3: A read from an empty buffer leaves `rd_data` at the last value read and does not move the pointers. A later write followed by a read returns the new sample.
- R4: A write while the buffer is full sets `ovfl` after that edge. A set takes priority over a clear in the same cycle.
- R5: `stat_rd` clears `ovfl` at the next edge. A buffer clear does not touch `ovfl`.
- R6: `fifo_clr` empties the buffer. Any read or write in the same cycle is ignored, and `rd_data` keeps its value.
- R7: `dev_rst` (and the asynchronous `rst_n`) empty the buffer, clear `ovfl`, set `rd_data` to 0 and rearm the pulse machine.
- R8: The threshold is selected by `chan_cnt` (0, 1, 2, 3 mean 1, 2, 3, 4 channels) and `trig_sel` (0 to 3):
  - 1 channel: 1, 4, 8, 14
  - 2 channels: 2, 4, 8, 12
  - 3 channels: 3, 6, 9, 12
  - 4 channels: 4, 8, 12
- R9: The reserved combination `chan_cnt`=3 with `trig_sel`=3 falls back to a threshold of 4.
- R10: In level mode (`av_pulse`=0), the line is active whenever fill is at or above the threshold. The change is visible right after the edge that changes the fill.
- R11: In pulse mode (`av_pulse`=1), the line is active for exactly one cycle, starting one clock after the fill first reaches the threshold. Another pulse comes only after the fill has dropped below the threshold and reached it again.
- R12: `av_high`=1 makes the line active high. `av_high`=0 makes it active low, with an idle level of 1.
- R13: After reset, with `av_pulse`=1 and `av_high`=1, `data_av`=0, `ovfl`=0 and `rd_data`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_rst | input | 1 | Synchronous device reset request |
| fifo_clr | input | 1 | Synchronous buffer clear request |
| wr_en | input | 1 | Push strobe from the front end |
| wr_data | input | 12 | Sample to push |
| rd_en | input | 1 | Pop strobe from the host |
| rd_data | output | 12 | Last popped sample |
| stat_rd | input | 1 | Host read of the status register holding the overflow flag |
| chan_cnt | input | 2 | Active channel count minus one |
| trig_sel | input | 2 | Threshold select |
| av_pulse | input | 1 | 1 = pulse, 0 = level |
| av_high | input | 1 | 1 = active high, 0 = active low |
| ovfl | output | 1 | Sticky overflow flag |
| data_av | output | 1 | Data-available indication |

## Verification
The bench walks all 16 threshold combinations, including the reserved fallback. It writes one sample short of each threshold and then one more, so an off-by-one or a swapped table entry shows up as an early or late assertion of `data_av`.

It also fills the buffer past capacity and reads everything back. A design that overwrote the oldest entry, or that accepted the 17th sample, would return wrong data. A read from an empty buffer that moved the pointers would corrupt the sample read afterwards.

Pulse mode is checked cycle by cycle, including the return to below the threshold. A level-style or a repeating pulse would be seen as a second active cycle. The bench also checks that clears ignore same-cycle traffic and that the overflow flag survives a buffer clear but not a device reset.

// File: rtl/sfq_pkg.sv
package sfq_pkg;
    typedef enum logic [1:0] {
        AV_ARMED = 2'd0,
        AV_FIRE  = 2'd1,
        AV_HELD  = 2'd2
    } av_state_e;
endpackage

// File: rtl/sfq_store.sv
module sfq_store #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          hold_clr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] fill,
    output logic          drop
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          full, wr_ok, rd_ok;

    assign full  = (fill == CW'(DEPTH));
    assign wr_ok = wr_en & ~full & ~flush;
    assign rd_ok = rd_en & (fill != '0) & ~flush;
    assign drop  = wr_en & full & ~flush;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (rd_ok) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (hold_clr) begin
            rd_data <= '0;
        end else if (rd_ok) begin
            rd_data <= mem[rd_ptr];
        end
    end
endmodule

// File: rtl/sfq_thresh.sv
module sfq_thresh #(
    parameter int CW = 5
) (
    input  logic [1:0]    chan_cnt,
    input  logic [1:0]    trig_sel,
    output logic [CW-1:0] thr
);
    int unsigned lvl;

    always_comb begin
        unique case ({chan_cnt, trig_sel})
            4'b00_00: lvl = 1;
            4'b00_01: lvl = 4;
            4'b00_10: lvl = 8;
            4'b00_11: lvl = 14;
            4'b01_00: lvl = 2;
            4'b01_01: lvl = 4;
            4'b01_10: lvl = 8;
            4'b01_11: lvl = 12;
            4'b10_00: lvl = 3;
            4'b10_01: lvl = 6;
            4'b10_10: lvl = 9;
            4'b10_11: lvl = 12;
            4'b11_00: lvl = 4;
            4'b11_01: lvl = 8;
            4'b11_10: lvl = 12;
            default:  lvl = 4;
        endcase
        thr = CW'(lvl);
    end
endmodule

// File: rtl/sfq_avgen.sv
module sfq_avgen
    import sfq_pkg::*;
#(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] fill,
    input  logic [CW-1:0] thr,
    input  logic          av_pulse,
    input  logic          av_high,
    output logic          data_av
);
    av_state_e state, nxt;
    logic      reached;
    logic      active;

    assign reached = (fill >= thr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= AV_ARMED;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        if (restart) begin
            nxt = AV_ARMED;
        end else begin
            unique case (state)
                AV_ARMED: if (reached) nxt = AV_FIRE;
                AV_FIRE:  nxt = reached ? AV_HELD : AV_ARMED;
                AV_HELD:  if (!reached) nxt = AV_ARMED;
                default:  nxt = AV_ARMED;
            endcase
        end
    end

    always_comb begin
        active  = av_pulse ? (state == AV_FIRE) : reached;
        data_av = av_high ? active : ~active;
    end
endmodule

// File: rtl/sfifo_trig.sv
module sfifo_trig #(
    parameter int W     = 12,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dev_rst,
    input  logic         fifo_clr,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    input  logic         stat_rd,
    input  logic [1:0]   chan_cnt,
    input  logic [1:0]   trig_sel,
    input  logic         av_pulse,
    input  logic         av_high,
    output logic         ovfl,
    output logic         data_av
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] fill;
    logic [CW-1:0] thr;
    logic          drop;
    logic          flush;

    assign flush = dev_rst | fifo_clr;

    sfq_store #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .hold_clr (dev_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .fill     (fill),
        .drop     (drop)
    );

    sfq_thresh #(.CW(CW)) u_thresh (
        .chan_cnt (chan_cnt),
        .trig_sel (trig_sel),
        .thr      (thr)
    );

    sfq_avgen #(.CW(CW)) u_avgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (flush),
        .fill     (fill),
        .thr      (thr),
        .av_pulse (av_pulse),
        .av_high  (av_high),
        .data_av  (data_av)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovfl <= 1'b0;
        end else if (dev_rst) begin
            ovfl <= 1'b0;
        end else if (drop) begin
            ovfl <= 1'b1;
        end else if (stat_rd) begin
            ovfl <= 1'b0;
        end
    end
endmodule

// File: rtl/sfq_chk.sv
module sfq_chk #(
    parameter int W     = 12,
    parameter int DEPTH = 16,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_rst,
    input logic          fifo_clr,
    input logic          wr_en,
    input logic          rd_en,
    input logic          stat_rd,
    input logic          av_pulse,
    input logic          av_high,
    input logic [CW-1:0] fill,
    input logic [W-1:0]  rd_data,
    input logic          ovfl,
    input logic          data_av
);
    // R2
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    // R4
    ovfl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && fill == CW'(DEPTH) && !dev_rst && !fifo_clr) |=> ovfl);

    // R5
    ovfl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !wr_en) |=> !ovfl);

    // R6
    clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_clr || dev_rst) |=> (fill == '0));

    // R3
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && fill == '0 && !dev_rst) |=> $stable(rd_data));

    // R11
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (av_pulse && av_high && data_av) |=> (!data_av || !av_pulse || !av_high));
endmodule

bind sfifo_trig sfq_chk #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_rst  (dev_rst),
    .fifo_clr (fifo_clr),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .stat_rd  (stat_rd),
    .av_pulse (av_pulse),
    .av_high  (av_high),
    .fill     (fill),
    .rd_data  (rd_data),
    .ovfl     (ovfl),
    .data_av  (data_av)
);

// File: tb/test_sfifo_trig.sv
module test_sfifo_trig;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_rst = 1'b0;
    logic        fifo_clr = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_data;
    logic        stat_rd = 1'b0;
    logic [1:0]  chan_cnt = 2'd0;
    logic [1:0]  trig_sel = 2'd0;
    logic        av_pulse = 1'b1;
    logic        av_high = 1'b1;
    logic        ovfl;
    logic        data_av;

    int n_checks = 0;
    int n_errors = 0;
    bit reported = 1'b0;

    // expected thresholds, index = chan_cnt*4 + trig_sel
    localparam int unsigned THR_TAB [16] = '{1, 4, 8, 14, 2, 4, 8, 12,
                                             3, 6, 9, 12, 4, 8, 12, 4};

    always #4 clk = ~clk;

    sfifo_trig i_sfifo_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_rst  (dev_rst),
        .fifo_clr (fifo_clr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_data  (rd_data),
        .stat_rd  (stat_rd),
        .chan_cnt (chan_cnt),
        .trig_sel (trig_sel),
        .av_pulse (av_pulse),
        .av_high  (av_high),
        .ovfl     (ovfl),
        .data_av  (data_av)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic push(input logic [11:0] d);
        wr_en = 1'b1;
        wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic clear();
        fifo_clr = 1'b1;
        tick();
        fifo_clr = 1'b0;
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        report();
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R13 reset state
        check("R13 data_av", 32'(data_av), 32'd0);
        check("R13 ovfl", 32'(ovfl), 32'd0);
        check("R13 rd_data", 32'(rd_data), 32'd0);

        // threshold table walk, level mode active high (R8, R9, R10)
        av_pulse = 1'b0;
        av_high = 1'b1;
        for (int i = 0; i < 16; i++) begin
            string tg;
            tg = (i == 15) ? "R9 reserved fallback" : "R8 threshold";
            chan_cnt = 2'(i / 4);
            trig_sel = 2'(i % 4);
            clear();
            for (int k = 0; k < int'(THR_TAB[i]) - 1; k++) push(12'(k));
            check({tg, " below (R10)"}, 32'(data_av), 32'd0);
            push(12'h0FF);
            check({tg, " reached (R10)"}, 32'(data_av), 32'd1);
        end

        // R1 ordering, R3 empty read
        chan_cnt = 2'd0;
        trig_sel = 2'd0;
        clear();
        for (int k = 0; k < 5; k++) push(12'h101 + 12'(k));
        for (int k = 0; k < 5; k++) begin
            pop();
            check("R1 order", 32'(rd_data), 32'(12'h101 + 12'(k)));
        end
        pop();
        check("R3 empty read holds", 32'(rd_data), 32'h105);
        push(12'h2AA);
        pop();
        check("R3 pointers intact", 32'(rd_data), 32'h2AA);

        // R2, R4 overflow
        clear();
        for (int k = 0; k < 17; k++) push(12'h300 + 12'(k));
        check("R4 ovfl set", 32'(ovfl), 32'd1);
        for (int k = 0; k < 16; k++) begin
            pop();
            check("R2 stored data kept", 32'(rd_data), 32'(12'h300 + 12'(k)));
        end
        pop();
        check("R2 17th dropped", 32'(rd_data), 32'h30F);
        stat_rd = 1'b1;
        tick();
        stat_rd = 1'b0;
        check("R5 status read clears", 32'(ovfl), 32'd0);

        // R4 set wins over status read
        for (int k = 0; k < 16; k++) push(12'h400 + 12'(k));
        wr_en = 1'b1;
        wr_data = 12'h4FF;
        stat_rd = 1'b1;
        tick();
        wr_en = 1'b0;
        stat_rd = 1'b0;
        check("R4 set beats clear", 32'(ovfl), 32'd1);

        // R5 / R6 buffer clear
        clear();
        check("R5 ovfl survives clear", 32'(ovfl), 32'd1);
        pop();
        check("R6 clear keeps rd_data", 32'(rd_data), 32'h30F);
        push(12'h011);
        push(12'h022);
        fifo_clr = 1'b1;
        wr_en = 1'b1;
        wr_data = 12'h077;
        rd_en = 1'b1;
        tick();
        fifo_clr = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        check("R6 read ignored in clear", 32'(rd_data), 32'h30F);
        push(12'h033);
        pop();
        check("R6 write ignored in clear", 32'(rd_data), 32'h033);

        // R7 device reset
        push(12'h0AB);
        dev_rst = 1'b1;
        tick();
        dev_rst = 1'b0;
        check("R7 ovfl cleared", 32'(ovfl), 32'd0);
        check("R7 rd_data cleared", 32'(rd_data), 32'd0);
        pop();
        check("R7 buffer emptied", 32'(rd_data), 32'd0);

        // R11 pulse mode, active high, threshold 4
        av_pulse = 1'b1;
        av_high = 1'b1;
        chan_cnt = 2'd0;
        trig_sel = 2'd1;
        clear();
        for (int k = 0; k < 3; k++) push(12'(k));
        check("R11 below", 32'(data_av), 32'd0);
        push(12'h003);
        check("R11 lag cycle", 32'(data_av), 32'd0);
        tick();
        check("R11 pulse", 32'(data_av), 32'd1);
        tick();
        check("R11 single cycle", 32'(data_av), 32'd0);
        push(12'h004);
        tick();
        check("R11 no repeat above", 32'(data_av), 32'd0);
        pop();
        pop();
        tick();
        check("R11 below again", 32'(data_av), 32'd0);
        push(12'h005);
        tick();
        check("R11 rearmed pulse", 32'(data_av), 32'd1);
        tick();
        check("R11 rearmed single", 32'(data_av), 32'd0);

        // R12 polarity, level active low, threshold 1
        av_pulse = 1'b0;
        av_high = 1'b0;
        trig_sel = 2'd0;
        clear();
        check("R12 low level idle", 32'(data_av), 32'd1);
        push(12'h001);
        check("R12 low level active", 32'(data_av), 32'd0);

        // R12 pulse active low
        av_pulse = 1'b1;
        clear();
        check("R12 low pulse idle", 32'(data_av), 32'd1);
        push(12'h002);
        check("R12 low pulse lag", 32'(data_av), 32'd1);
        tick();
        check("R12 low pulse active", 32'(data_av), 32'd0);
        tick();
        check("R12 low pulse end", 32'(data_av), 32'd1);

        report();
        $finish;
    end
endmodule